// File: doc/BRIEF.md
# Serial Port Register and Status Controller

This block is the register side of a byte-oriented asynchronous serial port. A host reaches eight byte-wide registers over a simple strobed bus. The registers hold the frame mode, a bit-rate divisor, control enables, a transmit byte, a status byte, a receive byte and two spare mode registers. The bit shifting itself sits outside the block. On the transmit side the block hands a whole byte to an external serializer with a one-cycle start pulse. On the receive side it accepts a whole byte, or a break indication, from an external deserializer.

A frame-done strobe from the bit-rate timer marks the end of each transmitted frame. The transmit path is single-buffered. A pair of flags, data-empty and transmit-end, decides whether a byte written by the host goes out at once or waits for the frame in flight to end. The receive path is also single-buffered. It records overrun and framing (break) errors, and it only lets the host clear an error flag after the host has seen it in a status read.

Four interrupt lines come out of the block. Receive and transmit-empty are one-cycle pulses. Transmit-end and error are levels.

Top module: `sport_ctrl`

## Requirements
- R1: The register select is the low 3 address bits, and all higher address bits are ignored. The selects are 0 mode, 1 bit-rate, 2 control, 3 transmit data, 4 status, 5 receive data, 6 spare-1 and 7 spare-2. Read data appears on bus_rdata in the cycle after bus_rd. The spare registers read back what was last written to them.
- R2: After reset, status reads 0x84, bit-rate and transmit data read 0xFF, and every other register reads 0x00. All interrupt lines and tx_start are low.
- R3: A write to mode or bit-rate is dropped while control bit 5 (transmit enable) or control bit 4 (receive enable) is 1. Otherwise the write is stored, and it shows on cfg_mode or cfg_rate.
- R4: A control write whose data has bit 5 set forces status bit 7 (data-empty) and status bit 2 (transmit-end) to 1. It also pulses irq_tx_empty when bit 7 (transmit interrupt enable) of the written data is 1.
- R5: A control write with bit 2 (transmit-end interrupt enable) at 0 drops irq_tx_end. A control write with bit 6 (receive interrupt enable) at 0 drops irq_err.
- R6: A transmit-data write while transmit-end is 1 starts a frame at once. tx_start pulses for one cycle with tx_byte equal to the written byte, transmit-end goes to 0, data-empty goes to 1 and irq_tx_end goes low. irq_tx_empty pulses if control bit 7 is 1.
- R7: A transmit-data write while transmit-end is 0 only clears data-empty. The byte waits and tx_start stays low.
- R8: A frame_done strobe while transmit-end is 0 does one of two things. If data-empty is 0, it starts the waiting byte, sets data-empty and pulses irq_tx_empty when enabled. Otherwise it sets transmit-end and raises the irq_tx_end level when control bit 2 is 1. A frame_done strobe while transmit-end is 1 has no effect.
- R9: A received byte, with receive enable 1 and status bit 6 (receive-full) 0, is stored and sets receive-full. It also pulses irq_rx when control bit 6 is 1. Bytes that arrive while receive enable is 0 are ignored.
- R10: A received byte that arrives while receive-full is 1 sets status bit 5 (overrun) and leaves the stored byte unchanged. It also raises irq_err when control bit 6 is 1.
- R11: Reading receive data clears receive-full. A break indication sets status bit 4 (framing error) and raises irq_err when control bit 6 is 1.
- R12: A status write stores bit 0 and can only clear error bits 3 to 5. An error bit clears only when 0 is written to it and the latest status read since the previous status write saw it at 1. Writing 1 has no effect, and bits 1, 2, 6 and 7 are unchanged.
- R13: A status write drops irq_err when it leaves all error bits at 0 and the preceding status read had seen at least one error bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address, low 3 bits decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| frame_done | input | 1 | End-of-frame strobe from the bit-rate timer |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break detected on the line |
| tx_start | output | 1 | One-cycle frame start for the serializer |
| tx_byte | output | 8 | Byte of the frame most recently started |
| irq_err | output | 1 | Error interrupt, level |
| irq_rx | output | 1 | Receive interrupt, pulse |
| irq_tx_empty | output | 1 | Transmit-empty interrupt, pulse |
| irq_tx_end | output | 1 | Transmit-end interrupt, level |
| cfg_mode | output | 8 | Current mode register |
| cfg_rate | output | 8 | Current bit-rate register |
| cfg_ctrl | output | 8 | Current control register |

## Verification
The bound checker checks the following relations on every cycle:
- A mode or bit-rate write is dropped while either enable is set.
- A frame start always leaves transmit-end and its interrupt low.
- The transmit-end interrupt never stands without its flag.
- A receive pulse always comes with receive-full set.
- An overrun keeps the stored byte.
- Error flags rise only on a received byte or a break.

Some behaviours depend on an ordered series of bus accesses, and only the bench's directed scenarios can show them:
- The status read-then-write protocol that clears an error.
- The queued byte that goes out on the next frame end.
- Interrupt pulses counted against each trigger.
- Register aliasing through the upper address bits.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int NREG   = 1 << SEL_W;

  // register selects
  localparam int A_MODE  = 0;
  localparam int A_RATE  = 1;
  localparam int A_CTRL  = 2;
  localparam int A_TDATA = 3;
  localparam int A_STAT  = 4;
  localparam int A_RDATA = 5;
  localparam int A_EXT1  = 6;
  localparam int A_EXT2  = 7;

  // control bits
  localparam int C_TEIE = 2;
  localparam int C_RE   = 4;
  localparam int C_TE   = 5;
  localparam int C_RIE  = 6;
  localparam int C_TIE  = 7;

  // status bits
  localparam int S_MPBT = 0;
  localparam int S_MPB  = 1;
  localparam int S_TEND = 2;
  localparam int S_PER  = 3;
  localparam int S_FER  = 4;
  localparam int S_ORER = 5;
  localparam int S_RDRF = 6;
  localparam int S_TDRE = 7;

  localparam logic [BYTE_W-1:0] RST_RATE  = 8'hFF;
  localparam logic [BYTE_W-1:0] RST_TDATA = 8'hFF;

  // error flags inside the receive path: [0] parity, [1] framing, [2] overrun
  typedef struct packed {
    logic ovr;
    logic frm;
    logic par;
  } err_flags_t;
endpackage

// File: rtl/sport_cfg_regs.sv
module sport_cfg_regs
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   wr_hit,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] rate_q,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] ext1_q,
  output logic [BYTE_W-1:0] ext2_q
);
  logic locked;
  assign locked = ctrl_q[C_TE] | ctrl_q[C_RE];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      rate_q <= RST_RATE;
      ctrl_q <= '0;
      ext1_q <= '0;
      ext2_q <= '0;
    end else begin
      if (wr_hit[A_MODE] && !locked) mode_q <= wdata;
      if (wr_hit[A_RATE] && !locked) rate_q <= wdata;
      if (wr_hit[A_CTRL]) ctrl_q <= wdata;
      if (wr_hit[A_EXT1]) ext1_q <= wdata;
      if (wr_hit[A_EXT2]) ext2_q <= wdata;
    end
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tdata_wr,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              frame_done,
  input  logic              tie,
  input  logic              teie,
  output logic              tdre_q,
  output logic              tend_q,
  output logic [BYTE_W-1:0] tdata_q,
  output logic              start_q,
  output logic [BYTE_W-1:0] byte_q,
  output logic              irq_txe_q,
  output logic              irq_tend_q
);
  logic              tdre_n, tend_n, start_n, txe_n, tendi_n;
  logic [BYTE_W-1:0] tdata_n, byte_n;

  // Order: frame end first, then the bus access of the same cycle.
  always_comb begin
    tdre_n  = tdre_q;
    tend_n  = tend_q;
    tdata_n = tdata_q;
    start_n = 1'b0;
    byte_n  = byte_q;
    txe_n   = 1'b0;
    tendi_n = irq_tend_q;

    if (frame_done && !tend_q) begin
      if (!tdre_q) begin
        start_n = 1'b1;
        byte_n  = tdata_q;
        tdre_n  = 1'b1;
        txe_n   = tie;
      end else begin
        tend_n = 1'b1;
        if (teie) tendi_n = 1'b1;
      end
    end

    if (ctrl_wr) begin
      if (wdata[C_TE]) begin
        tdre_n = 1'b1;
        tend_n = 1'b1;
        txe_n  = txe_n | wdata[C_TIE];
      end
      if (!wdata[C_TEIE]) tendi_n = 1'b0;
    end

    if (tdata_wr) begin
      tdata_n = wdata;
      if (tend_n) begin
        start_n = 1'b1;
        byte_n  = wdata;
        tend_n  = 1'b0;
        tdre_n  = 1'b1;
        tendi_n = 1'b0;
        txe_n   = txe_n | tie;
      end else begin
        tdre_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tdre_q     <= 1'b1;
      tend_q     <= 1'b1;
      tdata_q    <= RST_TDATA;
      start_q    <= 1'b0;
      byte_q     <= '0;
      irq_txe_q  <= 1'b0;
      irq_tend_q <= 1'b0;
    end else begin
      tdre_q     <= tdre_n;
      tend_q     <= tend_n;
      tdata_q    <= tdata_n;
      start_q    <= start_n;
      byte_q     <= byte_n;
      irq_txe_q  <= txe_n;
      irq_tend_q <= tendi_n;
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_break,
  input  logic              re,
  input  logic              rie,
  input  logic              ctrl_wr,
  input  logic              rdata_rd,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              rdrf_q,
  output err_flags_t        err_q,
  output logic              mpbt_q,
  output logic [BYTE_W-1:0] rdata_q,
  output logic              irq_rx_q,
  output logic              irq_err_q
);
  err_flags_t        err_n, shadow_q, shadow_n, wr_err;
  logic              rdrf_n, mpbt_n, rxp_n, erri_n;
  logic [BYTE_W-1:0] rdata_n;

  assign wr_err = err_flags_t'(wdata[S_ORER:S_PER]);

  // Order: bus clears first, then line events, so a new event is never lost.
  always_comb begin
    rdrf_n   = rdrf_q;
    err_n    = err_q;
    mpbt_n   = mpbt_q;
    rdata_n  = rdata_q;
    shadow_n = shadow_q;
    rxp_n    = 1'b0;
    erri_n   = irq_err_q;

    if (stat_rd)  shadow_n = err_q;
    if (rdata_rd) rdrf_n = 1'b0;

    if (stat_wr) begin
      mpbt_n   = wdata[S_MPBT];
      err_n    = err_q & ~(shadow_q & ~wr_err);
      shadow_n = '0;
      if ((shadow_q != '0) && (err_n == '0)) erri_n = 1'b0;
    end

    if (ctrl_wr && !wdata[C_RIE]) erri_n = 1'b0;

    if (rx_valid && re) begin
      if (rdrf_n) begin
        err_n.ovr = 1'b1;
        if (rie) erri_n = 1'b1;
      end else begin
        rdata_n = rx_byte;
        rdrf_n  = 1'b1;
        rxp_n   = rie;
      end
    end

    if (rx_break) begin
      err_n.frm = 1'b1;
      if (rie) erri_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdrf_q    <= 1'b0;
      err_q     <= '0;
      mpbt_q    <= 1'b0;
      rdata_q   <= '0;
      shadow_q  <= '0;
      irq_rx_q  <= 1'b0;
      irq_err_q <= 1'b0;
    end else begin
      rdrf_q    <= rdrf_n;
      err_q     <= err_n;
      mpbt_q    <= mpbt_n;
      rdata_q   <= rdata_n;
      shadow_q  <= shadow_n;
      irq_rx_q  <= rxp_n;
      irq_err_q <= erri_n;
    end
  end
endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              frame_done,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_break,
  output logic              tx_start,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq_err,
  output logic              irq_rx,
  output logic              irq_tx_empty,
  output logic              irq_tx_end,
  output logic [BYTE_W-1:0] cfg_mode,
  output logic [BYTE_W-1:0] cfg_rate,
  output logic [BYTE_W-1:0] cfg_ctrl
);
  logic [SEL_W-1:0]  sel;
  logic [NREG-1:0]   wr_hit, rd_hit;
  logic [BYTE_W-1:0] ext1, ext2, tdata, rx_data, stat_byte;
  logic              st_tdre, st_tend, st_rdrf, st_mpbt;
  err_flags_t        st_err;

  assign sel = bus_addr[SEL_W-1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_hit[i] = bus_wr && (sel == SEL_W'(i));
    assign rd_hit[i] = bus_rd && (sel == SEL_W'(i));
  end

  sport_cfg_regs u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (wr_hit),
    .wdata  (bus_wdata),
    .mode_q (cfg_mode),
    .rate_q (cfg_rate),
    .ctrl_q (cfg_ctrl),
    .ext1_q (ext1),
    .ext2_q (ext2)
  );

  sport_tx u_tx (
    .clk        (clk),
    .rst        (rst),
    .tdata_wr   (wr_hit[A_TDATA]),
    .ctrl_wr    (wr_hit[A_CTRL]),
    .wdata      (bus_wdata),
    .frame_done (frame_done),
    .tie        (cfg_ctrl[C_TIE]),
    .teie       (cfg_ctrl[C_TEIE]),
    .tdre_q     (st_tdre),
    .tend_q     (st_tend),
    .tdata_q    (tdata),
    .start_q    (tx_start),
    .byte_q     (tx_byte),
    .irq_txe_q  (irq_tx_empty),
    .irq_tend_q (irq_tx_end)
  );

  sport_rx u_rx (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_break  (rx_break),
    .re        (cfg_ctrl[C_RE]),
    .rie       (cfg_ctrl[C_RIE]),
    .ctrl_wr   (wr_hit[A_CTRL]),
    .rdata_rd  (rd_hit[A_RDATA]),
    .stat_rd   (rd_hit[A_STAT]),
    .stat_wr   (wr_hit[A_STAT]),
    .wdata     (bus_wdata),
    .rdrf_q    (st_rdrf),
    .err_q     (st_err),
    .mpbt_q    (st_mpbt),
    .rdata_q   (rx_data),
    .irq_rx_q  (irq_rx),
    .irq_err_q (irq_err)
  );

  always_comb begin
    stat_byte         = '0;
    stat_byte[S_TDRE] = st_tdre;
    stat_byte[S_RDRF] = st_rdrf;
    stat_byte[S_ORER] = st_err.ovr;
    stat_byte[S_FER]  = st_err.frm;
    stat_byte[S_PER]  = st_err.par;
    stat_byte[S_TEND] = st_tend;
    stat_byte[S_MPB]  = 1'b0;
    stat_byte[S_MPBT] = st_mpbt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        3'd0:    bus_rdata <= cfg_mode;
        3'd1:    bus_rdata <= cfg_rate;
        3'd2:    bus_rdata <= cfg_ctrl;
        3'd3:    bus_rdata <= tdata;
        3'd4:    bus_rdata <= stat_byte;
        3'd5:    bus_rdata <= rx_data;
        3'd6:    bus_rdata <= ext1;
        default: bus_rdata <= ext2;
      endcase
    end
  end
endmodule

// File: rtl/sport_chk.sv
module sport_chk
  import sport_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_valid,
  input logic              rx_break,
  input logic              tx_start,
  input logic              irq_tx_end,
  input logic              irq_rx,
  input logic [BYTE_W-1:0] cfg_mode,
  input logic [BYTE_W-1:0] cfg_rate,
  input logic [BYTE_W-1:0] cfg_ctrl,
  input logic              st_tend,
  input logic              st_rdrf,
  input logic [2:0]        st_err,
  input logic [BYTE_W-1:0] rx_data
);
  logic [SEL_W-1:0] sel;
  logic             lock;
  assign sel  = bus_addr[SEL_W-1:0];
  assign lock = cfg_ctrl[C_TE] | cfg_ctrl[C_RE];

  a_r3_mode_locked: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == 3'd0 && lock) |=> $stable(cfg_mode));

  a_r3_rate_locked: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == 3'd1 && lock) |=> $stable(cfg_rate));

  a_r6_start_clears_tend: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (!st_tend && !irq_tx_end));

  a_r8_tend_irq_has_flag: assert property (@(posedge clk) disable iff (rst)
    irq_tx_end |-> st_tend);

  a_r9_rx_pulse_has_flag: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> st_rdrf);

  a_r10_overrun_keeps_byte: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_ctrl[C_RE] && st_rdrf && !(bus_rd && sel == 3'd5))
    |=> (st_err[2] && $stable(rx_data)));

  a_r12_err_rises_on_event: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !rx_break) |=> ((st_err & ~$past(st_err)) == 3'b000));
endmodule

bind sport_ctrl sport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .rx_valid   (rx_valid),
  .rx_break   (rx_break),
  .tx_start   (tx_start),
  .irq_tx_end (irq_tx_end),
  .irq_rx     (irq_rx),
  .cfg_mode   (cfg_mode),
  .cfg_rate   (cfg_rate),
  .cfg_ctrl   (cfg_ctrl),
  .st_tend    (st_tend),
  .st_rdrf    (st_rdrf),
  .st_err     (st_err),
  .rx_data    (rx_data)
);

// File: tb/sim_sport_ctrl.sv
module sim_sport_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       frame_done = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_start, irq_err, irq_rx, irq_tx_empty, irq_tx_end;
  logic [7:0] tx_byte, cfg_mode, cfg_rate, cfg_ctrl;

  int n_chk = 0, n_fail = 0;
  int cnt_rxp = 0, cnt_txe = 0, cnt_start = 0;
  logic [7:0] last_byte = '0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  sport_ctrl #(.ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_done(frame_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_break(rx_break), .tx_start(tx_start), .tx_byte(tx_byte),
    .irq_err(irq_err), .irq_rx(irq_rx), .irq_tx_empty(irq_tx_empty),
    .irq_tx_end(irq_tx_end), .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
    .cfg_ctrl(cfg_ctrl)
  );

  // pulse monitor, sampled between edges
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (irq_rx) cnt_rxp++;
      if (irq_tx_empty) cnt_txe++;
      if (tx_start) begin cnt_start++; last_byte = tx_byte; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    chk(req, int'(v), int'(e));
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic rx_brk();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 irq lines", int'({irq_err, irq_rx, irq_tx_empty, irq_tx_end, tx_start}), 0);
    expect_reg("R2 mode", 8'd0, 8'h00);
    expect_reg("R2 rate", 8'd1, 8'hFF);
    expect_reg("R2 ctrl", 8'd2, 8'h00);
    expect_reg("R2 tdata", 8'd3, 8'hFF);
    expect_reg("R2 status", 8'd4, 8'h84);
    expect_reg("R2 rdata", 8'd5, 8'h00);
    expect_reg("R2 ext1", 8'd6, 8'h00);
    expect_reg("R2 ext2", 8'd7, 8'h00);
    expect_reg("R1 status alias", 8'hF4, 8'h84);
    wr(8'h0E, 8'h5A);
    expect_reg("R1 ext1 alias write", 8'd6, 8'h5A);
    wr(8'd7, 8'hC3);
    expect_reg("R1 ext2", 8'h2F, 8'hC3);
  endtask

  task automatic t_lock();
    wr(8'd0, 8'h21);
    expect_reg("R3 mode open", 8'd0, 8'h21);
    chk("R3 cfg_mode", int'(cfg_mode), 'h21);
    wr(8'd2, 8'h10);
    wr(8'd0, 8'h33);
    wr(8'd1, 8'h10);
    expect_reg("R3 mode locked", 8'd0, 8'h21);
    expect_reg("R3 rate locked", 8'd1, 8'hFF);
    wr(8'd2, 8'h20);
    wr(8'd1, 8'h12);
    expect_reg("R3 rate locked by TE", 8'd1, 8'hFF);
    wr(8'd2, 8'h00);
    wr(8'd1, 8'h40);
    expect_reg("R3 rate open", 8'd1, 8'h40);
    chk("R3 cfg_rate", int'(cfg_rate), 'h40);
  endtask

  task automatic t_tx();
    int t0, s0;
    t0 = cnt_txe; s0 = cnt_start;
    wr(8'd2, 8'hA0);
    chk("R4 txe pulse on enable", cnt_txe - t0, 1);
    expect_reg("R4 status after enable", 8'd4, 8'h84);
    wr(8'd3, 8'h3C);
    chk("R6 start count", cnt_start - s0, 1);
    chk("R6 start byte", int'(last_byte), 'h3C);
    chk("R6 txe pulse", cnt_txe - t0, 2);
    expect_reg("R6 status", 8'd4, 8'h80);
    wr(8'd3, 8'h5D);
    chk("R7 no start", cnt_start - s0, 1);
    expect_reg("R7 status queued", 8'd4, 8'h00);
    pulse_frame();
    chk("R8 queued start", cnt_start - s0, 2);
    chk("R8 queued byte", int'(last_byte), 'h5D);
    chk("R8 txe pulse", cnt_txe - t0, 3);
    expect_reg("R8 status", 8'd4, 8'h80);
    pulse_frame();
    expect_reg("R8 tend set", 8'd4, 8'h84);
    chk("R8 no tend irq when disabled", int'(irq_tx_end), 0);
    pulse_frame();
    chk("R8 idle frame_done ignored", cnt_start - s0, 2);
    expect_reg("R8 idle status", 8'd4, 8'h84);
  endtask

  task automatic t_tend_irq();
    wr(8'd2, 8'h24);
    wr(8'd3, 8'h11);
    pulse_frame();
    chk("R8 tend irq raised", int'(irq_tx_end), 1);
    repeat (3) @(negedge clk);
    chk("R8 tend irq is level", int'(irq_tx_end), 1);
    wr(8'd3, 8'h22);
    chk("R6 tend irq dropped by start", int'(irq_tx_end), 0);
    chk("R6 start byte 2", int'(last_byte), 'h22);
    pulse_frame();
    chk("R8 tend irq again", int'(irq_tx_end), 1);
    wr(8'd2, 8'h20);
    chk("R5 tend irq dropped by enable clear", int'(irq_tx_end), 0);
  endtask

  task automatic t_rx();
    int r0;
    r0 = cnt_rxp;
    wr(8'd2, 8'h50);
    rx_send(8'hA5);
    chk("R9 rx pulse", cnt_rxp - r0, 1);
    expect_reg("R9 status full", 8'd4, 8'hC4);
    expect_reg("R9 rdata", 8'd5, 8'hA5);
    expect_reg("R11 full cleared", 8'd4, 8'h84);
    rx_send(8'h01);
    rx_send(8'h02);
    chk("R10 err irq", int'(irq_err), 1);
    chk("R10 one rx pulse per stored byte", cnt_rxp - r0, 2);
    wr(8'd4, 8'h00);
    expect_reg("R12 no clear without read", 8'd4, 8'hE4);
    chk("R12 err irq kept", int'(irq_err), 1);
    wr(8'd4, 8'h20);
    expect_reg("R12 writing one no effect", 8'd4, 8'hE4);
    wr(8'd4, 8'h00);
    chk("R13 err irq dropped", int'(irq_err), 0);
    expect_reg("R12 overrun cleared", 8'd4, 8'hC4);
    expect_reg("R10 data kept", 8'd5, 8'h01);
    wr(8'd4, 8'h01);
    expect_reg("R12 mpbt stored", 8'd4, 8'h85);
    wr(8'd4, 8'h00);
    expect_reg("R12 mpbt cleared", 8'd4, 8'h84);
    rx_brk();
    chk("R11 break err irq", int'(irq_err), 1);
    expect_reg("R11 framing flag", 8'd4, 8'h94);
    wr(8'd2, 8'h10);
    chk("R5 err irq dropped by enable clear", int'(irq_err), 0);
    wr(8'd4, 8'h00);
    expect_reg("R12 framing cleared", 8'd4, 8'h84);
    wr(8'd2, 8'h00);
    r0 = cnt_rxp;
    rx_send(8'h77);
    expect_reg("R9 disabled ignored status", 8'd4, 8'h84);
    expect_reg("R9 disabled ignored data", 8'd5, 8'h01);
    wr(8'd2, 8'h10);
    rx_send(8'h66);
    chk("R9 no pulse without enable", cnt_rxp - r0, 0);
    expect_reg("R9 stored without irq", 8'd4, 8'hC4);
    expect_reg("R9 data 66", 8'd5, 8'h66);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lock();
    t_tx();
    t_tend_irq();
    t_rx();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule